// File: doc/BRIEF.md
# Receive Word Queue with Control/Status Register

This block buffers up to sixteen completed receive words coming from a serial shift receiver. It holds them until a bus read pops them out. The receiver hands over a word with a one-cycle strobe. The reader asserts a one-cycle pop, and the popped word appears on the data output one cycle later. If a word arrives while the queue is full, the oldest stored word is discarded to make room, and a sticky overflow flag is raised.

One 16-bit control/status word is reached through a simple select/write-enable port. It reports:

- the fill level;
- the overflow flag;
- a level-reached interrupt flag.

It also carries the writable controls:

- a pointer-hold control that empties the queue and keeps it empty;
- an interrupt enable;
- a 5-bit interrupt threshold;
- two write-one-to-clear strobes, one for each flag.

The interrupt output is the level flag gated by the enable.

Top module: `rxq_top`

## Requirements
- R1: Bits 12:8 of the control word give the number of stored words: 0 when empty, up to 16 (0x10) when full. Each accepted word adds one, and each effective pop removes one.
- R2: Words leave in arrival order. A pop of a non-empty queue places the oldest word on `pop_data` one cycle after the pop.
- R3: A word that arrives with 16 words stored and no pop in the same cycle is handled as follows: the oldest word is discarded, the level stays 16, and overflow bit 15 is set. Bit 15 then stays set until it is cleared.
- R4: Writing 1 to bit 14 clears the overflow flag, and writing 0 leaves it alone. Bit 14 and bit 6 always read 0. If a set and a clear of a flag happen in the same cycle, the set wins.
- R5: Bit 13 is read/write and comes out of reset as 1. While it is 0, the pointers and the level are forced to zero and incoming words are dropped without setting bit 15. Writing 1 resumes normal operation.
- R6: Interrupt flag bit 7 is set in the cycle after the level is at or above threshold bits 4:0. Writing 1 to bit 6 clears the flag. Bits 5 and 4:0 are read/write.
- R7: `irq` equals interrupt flag bit 7 ANDed with enable bit 5.
- R8: A pop of an empty queue leaves `pop_data` and the level unchanged.
- R9: After reset, the control word reads 0x201F and `irq` is 0.
- R10: A push together with a pop keeps the level constant when the queue holds 1 to 16 words. With 16 words held, this combination does not set bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Completed receive word strobe |
| rx_word | input | DW | Received word |
| pop | input | 1 | Read-side pop request |
| pop_data | output | DW | Last popped word |
| reg_sel | input | 1 | Control word select |
| reg_we | input | 1 | Control word write enable |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data (zero when not selected) |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume the following about the inputs:

- `rx_valid`, `pop` and the register write are single-cycle qualifiers sampled at every edge.
- Write data matters only while select and write enable are both high.
- No input carries unknown values after reset.

The bench respects these assumptions:

- It drives every input to a defined value on the falling edge.
- It keeps the select high so the word is always visible.
- It issues writes that mostly keep bit 13 set, so the queue runs most of the time while hold periods are still exercised.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DEPTH     = 16;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int PTR_W     = $clog2(DEPTH);
    localparam int CTL_W     = 16;

    // Field order is fixed: software decodes these bit positions.
    typedef struct packed {
        logic             ovf;
        logic             ovf_clr;
        logic             run;
        logic [CNT_W-1:0] level;
        logic             intf;
        logic             int_clr;
        logic             ien;
        logic [4:0]       thr;
    } ctl_word_t;

    localparam logic [CTL_W-1:0] CTL_RESET = 16'h201F;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    din,
    input  logic             pop,
    output logic [DW-1:0]    dout,
    output logic [CNT_W-1:0] level,
    output logic             drop_evt
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] lvl_q;
    logic             full, empty, push_go, pop_go;

    assign full     = (lvl_q == CNT_W'(DEPTH));
    assign empty    = (lvl_q == '0);
    assign push_go  = push && !flush;
    assign pop_go   = pop && !empty && !flush;
    assign drop_evt = push_go && full && !pop_go;

    always_ff @(posedge clk) begin
        if (push_go) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_go)          wr_q <= ptr_next(wr_q);
            if (pop_go || drop_evt) rd_q <= ptr_next(rd_q);
            if (push_go && !full && !pop_go)      lvl_q <= lvl_q + 1'b1;
            else if (pop_go && !push_go)          lvl_q <= lvl_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         dout <= '0;
        else if (pop_go) dout <= mem[rd_q];
    end

    assign level = lvl_q;

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  ctl_word_t        wd,
    input  logic [CNT_W-1:0] level,
    input  logic             drop_evt,
    output ctl_word_t        status,
    output logic             run,
    output logic             irq
);

    ctl_word_t rst_word;
    logic       run_q, ien_q, ovf_q, intf_q;
    logic [4:0] thr_q;
    logic       int_set;

    assign rst_word = ctl_word_t'(CTL_RESET);
    assign int_set  = ({1'b0, level} >= {1'b0, thr_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= rst_word.run;
            ien_q  <= rst_word.ien;
            thr_q  <= rst_word.thr;
            ovf_q  <= 1'b0;
            intf_q <= 1'b0;
        end else begin
            // set has priority over a same-cycle clear
            ovf_q  <= drop_evt || (ovf_q  && !(wr && wd.ovf_clr));
            intf_q <= int_set  || (intf_q && !(wr && wd.int_clr));
            if (wr) begin
                run_q <= wd.run;
                ien_q <= wd.ien;
                thr_q <= wd.thr;
            end
        end
    end

    always_comb begin
        status         = '0;
        status.ovf     = ovf_q;
        status.run     = run_q;
        status.level   = level;
        status.intf    = intf_q;
        status.ien     = ien_q;
        status.thr     = thr_q;
    end

    assign run = run_q;
    assign irq = intf_q && ien_q;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_word,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    input  logic          reg_sel,
    input  logic          reg_we,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          irq
);

    ctl_word_t        status_w;
    logic [CNT_W-1:0] level_w;
    logic             drop_w, run_w;

    rxq_store #(.DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (!run_w),
        .push     (rx_valid),
        .din      (rx_word),
        .pop      (pop),
        .dout     (pop_data),
        .level    (level_w),
        .drop_evt (drop_w)
    );

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_sel && reg_we),
        .wd       (ctl_word_t'(reg_wdata)),
        .level    (level_w),
        .drop_evt (drop_w),
        .status   (status_w),
        .run      (run_w),
        .irq      (irq)
    );

    assign reg_rdata = reg_sel ? 16'(status_w) : '0;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          pop,
    input logic          reg_sel,
    input logic          reg_we,
    input logic [15:0]   reg_wdata,
    input logic [15:0]   status,
    input logic [DW-1:0] pop_data,
    input logic          irq
);

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
        status[12:8] <= 5'd16);                                            // R1

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        status[13] |=> (status[12:8] <= $past(status[12:8]) + 5'd1));     // R1

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[15] && !(reg_sel && reg_we && reg_wdata[14])) |=> status[15]); // R3

    AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !status[13] |=> (status[12:8] == 5'd0));                           // R5

    AST_INT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[7]) |-> ($past(status[12:8]) >= $past(status[4:0]))); // R6

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status[5] && status[7]));                          // R7

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (status[12:8] == 5'd0 && pop && !rx_valid)
        |=> ($stable(pop_data) && status[12:8] == 5'd0));                  // R8

endmodule

bind rxq_top rxq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .pop       (pop),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .status    (16'(status_w)),
    .pop_data  (pop_data),
    .irq       (irq)
);

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_word = '0;
    logic          pop = 1'b0;
    logic [DW-1:0] pop_data;
    logic          reg_sel = 1'b1;
    logic          reg_we = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int            q[$];
    bit            m_ovf = 0, m_run = 1, m_ien = 0, m_intf = 0;
    int            m_thr = 31;
    logic [DW-1:0] m_last = '0;

    always #4 clk = ~clk;

    rxq_top #(.DW(DW)) dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word();
        return {m_ovf, 1'b0, m_run, 5'(q.size()), m_intf, 1'b0, m_ien, 5'(m_thr)};
    endfunction

    task automatic compare_all();
        chk("R1 level",     32'(reg_rdata[12:8]), 32'(q.size()));
        chk("R3 overflow",  32'(reg_rdata[15]),   32'(m_ovf));
        chk("R4 zero bits", 32'({reg_rdata[14], reg_rdata[6]}), 32'd0);
        chk("R5 hold bit",  32'(reg_rdata[13]),   32'(m_run));
        chk("R6 int flag",  32'(reg_rdata[7]),    32'(m_intf));
        chk("R6 ien/thr",   32'(reg_rdata[5:0]),  32'({m_ien, 5'(m_thr)}));
        chk("R7 irq",       32'(irq),             32'(m_intf && m_ien));
        chk("R2 pop_data",  32'(pop_data),        32'(m_last));
    endtask

    // one clock: drive at falling edge, update model, compare after rise
    task automatic step(bit push, logic [DW-1:0] din, bit p, bit we, logic [15:0] wd);
        bit set_int, set_ovf;
        @(negedge clk);
        rx_valid = push; rx_word = din; pop = p; reg_we = we; reg_wdata = wd;
        set_int = (q.size() >= m_thr);
        set_ovf = 0;
        if (!m_run) q.delete();
        else begin
            if (p && q.size() > 0) m_last = DW'(q.pop_front());
            if (push) begin
                if (q.size() == 16) begin void'(q.pop_front()); set_ovf = 1; end
                q.push_back(int'(din));
            end
        end
        m_ovf  = set_ovf || (m_ovf  && !(we && wd[14]));
        m_intf = set_int || (m_intf && !(we && wd[6]));
        if (we) begin m_run = wd[13]; m_ien = wd[5]; m_thr = int'(wd[4:0]); end
        @(posedge clk); #1;
        compare_all();
    endtask

    task automatic wr(logic [15:0] wd);
        step(0, '0, 0, 1, wd);
    endtask

    initial begin
        int lvl0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R9 reset word", 32'(reg_rdata), 32'h201F);
        chk("R9 reset irq",  32'(irq), 32'd0);

        // R8: pop on empty queue
        step(0, '0, 1, 0, '0);
        chk("R8 empty pop level", 32'(reg_rdata[12:8]), 32'd0);
        chk("R8 empty pop data",  32'(pop_data), 32'd0);

        // R3: fill 16 then one more
        for (int i = 0; i < 17; i++) step(1, DW'(16'h100 + i), 0, 0, '0);
        chk("R3 ovf set", 32'(reg_rdata[15]), 32'd1);
        // R10: push and pop while full must not disturb level
        step(1, 16'hBEEF, 1, 0, '0);
        chk("R10 full push+pop level", 32'(reg_rdata[12:8]), 32'd16);
        // R4: write 0 to bit 14 keeps flag, write 1 clears it
        wr(16'h201F);
        chk("R4 clear0 keeps", 32'(reg_rdata[15]), 32'd1);
        wr(16'h601F);
        chk("R4 clear1 clears", 32'(reg_rdata[15]), 32'd0);
        // R2: drain in order
        for (int i = 0; i < 17; i++) step(0, '0, 1, 0, '0);
        // R10: push+pop mid-level
        step(1, 16'h0011, 0, 0, '0);
        step(1, 16'h0022, 0, 0, '0);
        lvl0 = int'(reg_rdata[12:8]);
        step(1, 16'h0033, 1, 0, '0);
        chk("R10 push+pop level", 32'(reg_rdata[12:8]), 32'(lvl0));
        // R6/R7: threshold 2, enable, clear while condition persists
        wr(16'h2022);
        step(0, '0, 0, 0, '0);
        chk("R7 irq asserted", 32'(irq), 32'd1);
        wr(16'h2062);
        chk("R6 set beats clear", 32'(reg_rdata[7]), 32'd1);
        // R5: hold discards traffic
        wr(16'h0022);
        step(1, 16'h0044, 0, 0, '0);
        step(1, 16'h0055, 0, 0, '0);
        chk("R5 hold level", 32'(reg_rdata[12:8]), 32'd0);
        wr(16'h205F);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            bit ps, pp, w;
            logic [15:0] wd;
            ps = ($urandom_range(99) < 55);
            pp = ($urandom_range(99) < 45);
            w  = ($urandom_range(99) < 4);
            wd = 16'($urandom);
            wd[13] = ($urandom_range(9) != 0);
            wd[4:0] = 5'($urandom_range(20));
            step(ps, DW'($urandom), pp, w, wd);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule